// File: doc/BRIEF.md
# Cache Region Attribute Controller

This block holds the policy state for a small processor cache and classifies every bus access against it. Its state is a flush trigger, a two-bit control word and three 32-bit region bitmaps. The bitmaps mark a region as cacheable, as refreshed on write (updateable), or as one that forces a flush when written (disruptive). Each bitmap bit covers one 2 MB slice of a 64 MB space. The region index comes from address bits [25:21], and higher address bits are ignored.

Software reaches the state through a single register port. A selected register can be written plainly, or changed with a masked update where new = (old AND mask) XOR data. The old value is presented on the read data output in the same cycle as the request.

A bus monitor input carries each access address and its direction. For each access the block reports, combinationally, whether the access may be cached and whether a write must refresh the cached copy. A registered one-cycle flush pulse is raised after a flush-register write or after a write into a disruptive region.

Top module: `cache_region_ctrl`

## Requirements
- R1: A write request to selector 1 raises `flush_o` for exactly the following cycle, whatever data is written. A read of selector 1 raises no flush and returns 0.
- R2: Selector 2 is the control word. Bit 0 is the cache enable and drives `cache_en_o`. Bit 1 is the shared user/supervisor translation select and drives `shared_xlat_o`. Bits 31:2 always read as zero.
- R3: `acc_cacheable_o` is 1 exactly when `acc_valid_i` is 1, the cache is enabled, and bit n of the cacheable map (selector 3) is set, where n = `acc_addr_i[25:21]`. Address bits 31:26 have no effect.
- R4: `acc_update_o` is 1 only for a valid write access while the cache is enabled, and only when bit n of the updateable map (selector 4) is set. It is 0 for reads.
- R5: A valid write into a region whose bit in the disruptive map (selector 5) is set, while the cache is enabled, raises `flush_o` in the following cycle. Reads of that region, and writes to regions whose bit is clear, raise no flush.
- R6: When `reg_rmw_i` is 1, a write sets the selected register to (old AND `reg_mask_i`) XOR `reg_wdata_i`. When `reg_rmw_i` is 0, a write loads `reg_wdata_i`. In both cases `reg_rdata_o` shows the old value during the request cycle.
- R7: After reset the values are: cacheable 0xFC007FFF, updateable 0x00007FFF, disruptive 0xF0000000, control 0, and `flush_o` low.
- R8: While the cache enable is 0, every access reports not cacheable and not updateable, and a disruptive write raises no flush. A selector-1 write still flushes.
- R9: A selector-1 write and a disruptive write in the same cycle give a single one-cycle flush pulse.
- R10: A register write affects classification only from the next cycle. An access in the same cycle as the write is classified against the old value.
- R11: Selectors 0, 6 and 7 read as zero, and writes to them change no register and raise no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register port request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_rmw_i | input | 1 | 1 = masked update, 0 = plain write |
| reg_sel_i | input | 3 | Register selector (1 flush, 2 control, 3 cacheable, 4 updateable, 5 disruptive) |
| reg_wdata_i | input | 32 | Write data, or XOR term of a masked update |
| reg_mask_i | input | 32 | AND term of a masked update |
| reg_rdata_o | output | 32 | Current (old) value of the selected register |
| acc_valid_i | input | 1 | Monitored access present |
| acc_write_i | input | 1 | Monitored access is a write |
| acc_addr_i | input | 32 | Monitored access address |
| acc_cacheable_o | output | 1 | Access may be cached |
| acc_update_o | output | 1 | Write must refresh the cache copy |
| flush_o | output | 1 | One-cycle full flush request |
| cache_en_o | output | 1 | Global cache enable |
| shared_xlat_o | output | 1 | Shared user/supervisor translation select |

## Verification
The hardest case to reach is the collision of two flush sources in one cycle, because a flush-register write and a disruptive bus write must meet at the same clock edge. The bench drives both from one task at the same falling edge and then watches two following cycles, to prove that exactly one pulse appears. A second hard case is the one-cycle window in which an access sees the old map while a rewrite of that map is in flight. It is reached by presenting a bus access and a map write together and sampling the classification before and after the edge.

// File: rtl/cache_region_pkg.sv
package cache_region_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_MAPS = 3;
  localparam int SEL_W    = 3;

  localparam logic [SEL_W-1:0] SEL_FLUSH    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL     = 3'd2;
  localparam logic [SEL_W-1:0] SEL_MAP_BASE = 3'd3;

  // map order: 0 cacheable, 1 updateable, 2 disruptive
  localparam int MAP_CACHE   = 0;
  localparam int MAP_UPDATE  = 1;
  localparam int MAP_DISRUPT = 2;

  localparam logic [NUM_MAPS-1:0][DATA_W-1:0] MAP_RST = {
    32'hF000_0000, 32'h0000_7FFF, 32'hFC00_7FFF
  };

  function automatic logic [DATA_W-1:0] next_val(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] data_v,
    input logic [DATA_W-1:0] mask_v,
    input logic              rmw
  );
    return rmw ? ((old_v & mask_v) ^ data_v) : data_v;
  endfunction
endpackage

// File: rtl/crc_regfile.sv
module crc_regfile
  import cache_region_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int NMAPS = NUM_MAPS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic                       rmw_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [W-1:0]               wdata_i,
  input  logic [W-1:0]               mask_i,
  output logic [W-1:0]               rdata_o,
  output logic                       flush_wr_o,
  output logic [1:0]                 ctrl_o,
  output logic [NMAPS-1:0][W-1:0]    maps_o
);
  localparam int CTRL_W = 2;

  logic              wr;
  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      ctrl_ext;

  assign wr         = req_i & we_i;
  assign flush_wr_o = wr & (sel_i == SEL_FLUSH);
  assign ctrl_ext   = {{(W-CTRL_W){1'b0}}, ctrl_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr && sel_i == SEL_CTRL)
      ctrl_q <= CTRL_W'(next_val(ctrl_ext, wdata_i, mask_i, rmw_i));
  end

  for (genvar g = 0; g < NMAPS; g++) begin : g_map
    logic [W-1:0] map_q;
    logic         hit;
    assign hit = wr && (sel_i == SEL_W'(int'(SEL_MAP_BASE) + g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  map_q <= MAP_RST[g];
      else if (hit) map_q <= next_val(map_q, wdata_i, mask_i, rmw_i);
    end
    assign maps_o[g] = map_q;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_CTRL) rdata_o = ctrl_ext;
    for (int i = 0; i < NMAPS; i++)
      if (sel_i == SEL_W'(int'(SEL_MAP_BASE) + i)) rdata_o = maps_o[i];
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/crc_classifier.sv
module crc_classifier
  import cache_region_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int IDX_W = 5
) (
  input  logic             valid_i,
  input  logic             write_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [W-1:0]     cache_map_i,
  input  logic [W-1:0]     update_map_i,
  input  logic [W-1:0]     disrupt_map_i,
  output logic             cacheable_o,
  output logic             update_o,
  output logic             disrupt_o
);
  logic live;
  assign live        = valid_i & en_i;
  assign cacheable_o = live & cache_map_i[idx_i];
  assign update_o    = live & write_i & update_map_i[idx_i];
  assign disrupt_o   = live & write_i & disrupt_map_i[idx_i];
endmodule

// File: rtl/crc_flush_gen.sv
module crc_flush_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reg_flush_i,
  input  logic bus_flush_i,
  output logic flush_o
);
  // both sources merge into one registered pulse
  logic flush_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= reg_flush_i | bus_flush_i;
  end
  assign flush_o = flush_q;
endmodule

// File: rtl/cache_region_ctrl.sv
module cache_region_ctrl
  import cache_region_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic              reg_rmw_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [DATA_W-1:0] reg_mask_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              acc_cacheable_o,
  output logic              acc_update_o,
  output logic              flush_o,
  output logic              cache_en_o,
  output logic              shared_xlat_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [NUM_MAPS-1:0][DATA_W-1:0] maps;
  logic [1:0]       ctrl;
  logic             reg_flush;
  logic             bus_flush;
  logic [IDX_W-1:0] region_idx;
  logic             unused_addr;

  assign region_idx  = acc_addr_i[REGION_LSB +: IDX_W];
  assign unused_addr = ^{acc_addr_i[ADDR_W-1:REGION_LSB+IDX_W], acc_addr_i[REGION_LSB-1:0]};

  crc_regfile #(.W(DATA_W), .NMAPS(NUM_MAPS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (reg_req_i),
    .we_i       (reg_we_i),
    .rmw_i      (reg_rmw_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .mask_i     (reg_mask_i),
    .rdata_o    (reg_rdata_o),
    .flush_wr_o (reg_flush),
    .ctrl_o     (ctrl),
    .maps_o     (maps)
  );

  crc_classifier #(.W(DATA_W), .IDX_W(IDX_W)) u_class (
    .valid_i       (acc_valid_i),
    .write_i       (acc_write_i),
    .en_i          (ctrl[0]),
    .idx_i         (region_idx),
    .cache_map_i   (maps[MAP_CACHE]),
    .update_map_i  (maps[MAP_UPDATE]),
    .disrupt_map_i (maps[MAP_DISRUPT]),
    .cacheable_o   (acc_cacheable_o),
    .update_o      (acc_update_o),
    .disrupt_o     (bus_flush)
  );

  crc_flush_gen u_flush (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_flush_i (reg_flush),
    .bus_flush_i (bus_flush),
    .flush_o     (flush_o)
  );

  assign cache_en_o    = ctrl[0];
  assign shared_xlat_o = ctrl[1];
endmodule

// File: rtl/cache_region_ctrl_chk.sv
module cache_region_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_req_i,
  input logic        reg_we_i,
  input logic        reg_rmw_i,
  input logic [2:0]  reg_sel_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_mask_i,
  input logic [31:0] reg_rdata_o,
  input logic        acc_valid_i,
  input logic        acc_write_i,
  input logic        acc_cacheable_o,
  input logic        acc_update_o,
  input logic        flush_o,
  input logic        cache_en_o,
  input logic [31:0] cache_map
);
  AST_FLUSH_AFTER_CR1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_we_i && reg_sel_i == 3'd1) |=> flush_o); // R1

  AST_CTRL_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 3'd2) |-> (reg_rdata_o[31:2] == 30'd0)); // R2

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cache_en_o |-> (!acc_cacheable_o && !acc_update_o)); // R8

  AST_UPDATE_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_update_o |-> (acc_valid_i && acc_write_i)); // R4

  AST_FLUSH_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flush_o) |-> ($past(reg_req_i && reg_we_i) || $past(acc_valid_i && acc_write_i))); // R5

  AST_RMW_CACHEABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_we_i && reg_rmw_i && reg_sel_i == 3'd3) |=>
      (cache_map == (($past(cache_map) & $past(reg_mask_i)) ^ $past(reg_wdata_i)))); // R6

  AST_UNUSED_SEL_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 3'd0 || reg_sel_i > 3'd5) |-> (reg_rdata_o == 32'd0)); // R11
endmodule

bind cache_region_ctrl cache_region_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_req_i       (reg_req_i),
  .reg_we_i        (reg_we_i),
  .reg_rmw_i       (reg_rmw_i),
  .reg_sel_i       (reg_sel_i),
  .reg_wdata_i     (reg_wdata_i),
  .reg_mask_i      (reg_mask_i),
  .reg_rdata_o     (reg_rdata_o),
  .acc_valid_i     (acc_valid_i),
  .acc_write_i     (acc_write_i),
  .acc_cacheable_o (acc_cacheable_o),
  .acc_update_o    (acc_update_o),
  .flush_o         (flush_o),
  .cache_en_o      (cache_en_o),
  .cache_map       (maps[0])
);

// File: tb/cache_region_ctrl_bench.sv
module cache_region_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0, reg_rmw_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_mask_i = '0;
  logic [31:0] reg_rdata_o;
  logic        acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic        acc_cacheable_o, acc_update_o, flush_o, cache_en_o, shared_xlat_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cache_region_ctrl u_cache_region_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_req_i(reg_req_i), .reg_we_i(reg_we_i), .reg_rmw_i(reg_rmw_i),
    .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .reg_mask_i(reg_mask_i),
    .reg_rdata_o(reg_rdata_o),
    .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i), .acc_addr_i(acc_addr_i),
    .acc_cacheable_o(acc_cacheable_o), .acc_update_o(acc_update_o),
    .flush_o(flush_o), .cache_en_o(cache_en_o), .shared_xlat_o(shared_xlat_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // starts and ends on a falling edge; old = value shown during request
  task automatic reg_op(input logic [2:0] sel, input logic we, input logic rmw,
                        input logic [31:0] wd, input logic [31:0] mk,
                        output logic [31:0] old);
    reg_req_i = 1'b1; reg_we_i = we; reg_rmw_i = rmw;
    reg_sel_i = sel; reg_wdata_i = wd; reg_mask_i = mk;
    #1 old = reg_rdata_o;
    @(negedge clk);
    reg_req_i = 1'b0; reg_we_i = 1'b0; reg_rmw_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] v);
    reg_op(sel, 1'b0, 1'b0, '0, '0, v);
  endtask

  task automatic access(input logic [31:0] a, input logic w,
                        output logic c, output logic u, output logic f);
    acc_valid_i = 1'b1; acc_write_i = w; acc_addr_i = a;
    #1 c = acc_cacheable_o; u = acc_update_o;
    @(negedge clk);
    f = flush_o;
    acc_valid_i = 1'b0; acc_write_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R7 flush idle", 32'(flush_o), 32'd0);
    chk("R7 enable off", 32'(cache_en_o), 32'd0);
    rd(3'd3, v); chk("R7 cacheable reset", v, 32'hFC00_7FFF);
    rd(3'd4, v); chk("R7 updateable reset", v, 32'h0000_7FFF);
    rd(3'd5, v); chk("R7 disruptive reset", v, 32'hF000_0000);
    rd(3'd2, v); chk("R7 control reset", v, 32'd0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    reg_op(3'd2, 1'b1, 1'b0, 32'hFFFF_FFFF, '0, v);
    rd(3'd2, v); chk("R2 control upper bits zero", v, 32'd3);
    chk("R2 enable out", 32'(cache_en_o), 32'd1);
    chk("R2 shared xlat out", 32'(shared_xlat_o), 32'd1);
    reg_op(3'd2, 1'b1, 1'b1, 32'd0, 32'hFFFF_FFFD, v);
    chk("R2 rmw old", v, 32'd3);
    chk("R2 shared cleared", 32'(shared_xlat_o), 32'd0);
    chk("R2 enable kept", 32'(cache_en_o), 32'd1);
  endtask

  task automatic t_rmw();
    logic [31:0] v;
    reg_op(3'd3, 1'b1, 1'b1, 32'd0, 32'hFFFF_FCFF, v);
    chk("R6 rmw returns old", v, 32'hFC00_7FFF);
    rd(3'd3, v); chk("R6 rmw and result", v, 32'hFC00_7CFF);
    reg_op(3'd4, 1'b1, 1'b1, 32'h8000_0001, 32'hFFFF_FFFF, v);
    rd(3'd4, v); chk("R6 rmw xor result", v, 32'h8000_7FFE);
    reg_op(3'd5, 1'b1, 1'b0, 32'h0000_000F, 32'h0, v);
    chk("R6 plain returns old", v, 32'hF000_0000);
    rd(3'd5, v); chk("R6 plain write", v, 32'h0000_000F);
    reg_op(3'd5, 1'b1, 1'b0, 32'hF000_0000, 32'h0, v);
  endtask

  task automatic t_classify();
    logic c, u, f;
    access(32'h0000_0000, 1'b0, c, u, f); chk("R3 region0 cacheable", 32'(c), 32'd1);
    access(32'h0100_0000, 1'b0, c, u, f); chk("R3 region8 not cacheable", 32'(c), 32'd0);
    access(32'h03E0_0000, 1'b0, c, u, f); chk("R3 region31 cacheable", 32'(c), 32'd1);
    access(32'h0320_0000, 1'b0, c, u, f); chk("R3 region25 not cacheable", 32'(c), 32'd0);
    access(32'hFD00_0000, 1'b0, c, u, f); chk("R3 high bits ignored", 32'(c), 32'd0);
    access(32'hFC00_0004, 1'b0, c, u, f); chk("R3 high bits ignored r0", 32'(c), 32'd1);
    access(32'h0020_0000, 1'b1, c, u, f); chk("R4 region1 write update", 32'(u), 32'd1);
    access(32'h0020_0000, 1'b0, c, u, f); chk("R4 read no update", 32'(u), 32'd0);
    access(32'h0000_0000, 1'b1, c, u, f); chk("R4 region0 not updateable", 32'(u), 32'd0);
    access(32'h03E0_0000, 1'b1, c, u, f); chk("R4 region31 updateable", 32'(u), 32'd1);
  endtask

  task automatic t_disrupt();
    logic c, u, f;
    access(32'h0380_0000, 1'b1, c, u, f); chk("R5 disruptive write flush", 32'(f), 32'd1);
    @(negedge clk); chk("R5 pulse one cycle", 32'(flush_o), 32'd0);
    access(32'h0380_0000, 1'b0, c, u, f); chk("R5 disruptive read no flush", 32'(f), 32'd0);
    access(32'h0000_0000, 1'b1, c, u, f); chk("R5 plain write no flush", 32'(f), 32'd0);
  endtask

  task automatic t_cr1();
    logic [31:0] v;
    reg_op(3'd1, 1'b1, 1'b0, 32'd0, 32'd0, v);
    chk("R1 cr1 write flush", 32'(flush_o), 32'd1);
    @(negedge clk); chk("R1 flush one cycle", 32'(flush_o), 32'd0);
    reg_op(3'd1, 1'b1, 1'b1, 32'h1234_5678, 32'hFFFF_FFFF, v);
    chk("R1 cr1 any data flush", 32'(flush_o), 32'd1);
    rd(3'd1, v);
    chk("R1 cr1 read value", v, 32'd0);
    chk("R1 cr1 read no flush", 32'(flush_o), 32'd0);
  endtask

  task automatic t_same();
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_sel_i = 3'd1; reg_wdata_i = '0;
    acc_valid_i = 1'b1; acc_write_i = 1'b1; acc_addr_i = 32'h03C0_0000;
    @(negedge clk);
    reg_req_i = 1'b0; reg_we_i = 1'b0; acc_valid_i = 1'b0; acc_write_i = 1'b0;
    chk("R9 merged flush high", 32'(flush_o), 32'd1);
    @(negedge clk); chk("R9 single pulse", 32'(flush_o), 32'd0);
  endtask

  task automatic t_next_cycle();
    logic [31:0] v;
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_sel_i = 3'd3; reg_wdata_i = 32'd0;
    acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_addr_i = 32'h0;
    #1 chk("R10 same cycle old map", 32'(acc_cacheable_o), 32'd1);
    @(negedge clk);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
    #1 chk("R10 next cycle new map", 32'(acc_cacheable_o), 32'd0);
    @(negedge clk);
    acc_valid_i = 1'b0;
    reg_op(3'd3, 1'b1, 1'b0, 32'hFC00_7CFF, '0, v);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    logic c, u, f;
    reg_op(3'd2, 1'b1, 1'b0, 32'd0, '0, v);
    access(32'h0000_0000, 1'b0, c, u, f); chk("R8 disabled not cacheable", 32'(c), 32'd0);
    access(32'h03E0_0000, 1'b1, c, u, f); chk("R8 disabled no update", 32'(u), 32'd0);
    access(32'h0380_0000, 1'b1, c, u, f); chk("R8 disabled no disrupt flush", 32'(f), 32'd0);
    reg_op(3'd1, 1'b1, 1'b0, 32'd0, '0, v);
    chk("R8 cr1 still flushes", 32'(flush_o), 32'd1);
    @(negedge clk);
  endtask

  task automatic t_unused();
    logic [31:0] v;
    reg_op(3'd6, 1'b1, 1'b0, 32'hFFFF_FFFF, '0, v);
    chk("R11 unused write no flush", 32'(flush_o), 32'd0);
    reg_op(3'd0, 1'b1, 1'b0, 32'hFFFF_FFFF, '0, v);
    reg_op(3'd7, 1'b1, 1'b0, 32'hFFFF_FFFF, '0, v);
    rd(3'd6, v); chk("R11 unused reads zero", v, 32'd0);
    rd(3'd2, v); chk("R11 control untouched", v, 32'd0);
    rd(3'd3, v); chk("R11 cacheable untouched", v, 32'hFC00_7CFF);
    rd(3'd4, v); chk("R11 updateable untouched", v, 32'h8000_7FFE);
    rd(3'd5, v); chk("R11 disruptive untouched", v, 32'hF000_0000);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    reg_op(3'd2, 1'b1, 1'b0, 32'd1, '0, v);
    t_rmw();
    t_classify();
    t_disrupt();
    t_cr1();
    t_same();
    t_next_cycle();
    t_disabled();
    t_unused();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule